// File: doc/BRIEF.md
# Bit-Clock Source and De-emphasis Select Detector

This block watches one shared input that carries one of two things: a free-running external bit clock, or a slow static level that asks for de-emphasis. Each master-clock cycle it samples the shared input and the frame clock. From these samples it decides whether an external bit clock is present. When one is present, the external clock is passed through to the bit-clock output. When none is present, the block makes its own bit clock by dividing the master clock. The divided clock is locked to the frame clock, and its rate follows the data format and the ratio of master clock to frame clock. While the internal bit clock is in use, the same input acts as the de-emphasis request. Its level is latched after several frames that agree.

All inputs are assumed synchronous to the master clock. Every output is a plain control signal. No data stream passes through the block, so it has no valid/ready handshake. The de-emphasis filter is outside this block; it only receives the enable.

Top module: `bclk_mode_sense`

## Requirements
- R1: When reset is released, the block is in internal bit-clock mode (`ext_mode_o` = 0) and de-emphasis is off (`deemph_en_o` = 0).
- R2: External mode is entered when 16 rising transitions of `shared_pin_i` occur between two consecutive frame-clock edges. Both rising and falling frame-clock edges count as boundaries. The count restarts at every frame-clock edge, so 15 rises before an edge and 15 after it do not enter the mode. `ext_mode_o` goes high on the clock edge that samples the 16th rise.
- R3: External mode is left on the falling frame-clock edge that completes the second frame in a row with no rising transition on `shared_pin_i`. A frame runs from one falling frame-clock edge to the next. Any rise inside a frame restarts this count.
- R4: In internal mode, `shared_pin_i` is sampled at each falling frame-clock edge. After 5 consecutive low samples, `deemph_en_o` becomes 1. A high sample restarts the run of low samples.
- R5: In internal mode, 5 consecutive high samples at falling frame-clock edges turn `deemph_en_o` off. A low sample restarts the run of high samples.
- R6: While external mode is active, `deemph_en_o` is held at 0. Samples are discarded, including the sample at the falling edge where external mode ends and the sample at the edge where it begins. After a return to internal mode, 5 fresh low samples are needed to turn de-emphasis on.
- R7: In internal mode the bit-clock period is N master-clock cycles. `ratio_sel_i` codes 0 to 4 mean master/frame ratios of 128, 192, 256, 384 and 512. For ratios 192 and 384 there are 48 bit clocks per frame. For the other ratios there are 32 bit clocks per frame when `wide_fmt_i` = 0 and 64 when it is 1. N is the master/frame ratio divided by the number of bit clocks per frame. Codes 5 to 7 act as ratio 256.
- R8: The internal bit clock restarts on every frame-clock edge. In the first master-clock cycle after the edge is sampled, `bit_clk_o` is low. It stays low for N/2 cycles, then stays high for N/2 cycles, and repeats.
- R9: In external mode, `bit_clk_o` follows `shared_pin_i` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_clk_i | input | 1 | Frame (word-select) clock, synchronous to clk |
| shared_pin_i | input | 1 | External bit clock or de-emphasis level |
| ratio_sel_i | input | 3 | Master/frame ratio code (0:128, 1:192, 2:256, 3:384, 4:512) |
| wide_fmt_i | input | 1 | Format selects 64 (1) or 32 (0) bit clocks per frame for ratios 128/256/512 |
| ext_mode_o | output | 1 | 1 while external bit-clock mode is active |
| deemph_en_o | output | 1 | Latched de-emphasis enable |
| bit_clk_o | output | 1 | Selected bit clock |

## Verification
The divider is swept over all ten combinations of ratio code and format flag. Each sampled period is compared with the value of N worked out in the bench, which shows both the ratio decode and the phase reset at the frame edge. Three bursts of rising edges on the shared input are used:
- 15 rises in one frame, which must not switch the mode;
- 15 rises on each side of a frame edge, which separates a per-frame count from a running count;
- a full 16 rises, which must switch the mode.

For the return to internal mode, the bench runs frames with one pin rise each, fully idle frames, and an idle run broken by a single rise. For de-emphasis, it applies runs of four and of five equal samples, a run broken by one opposite sample, and low levels held while external mode is active.

// File: rtl/bclk_mode_pkg.sv
`timescale 1ns/1ps
package bclk_mode_pkg;

  localparam int DIV_W = 5;

  typedef enum logic [2:0] {
    RATIO_128 = 3'd0,
    RATIO_192 = 3'd1,
    RATIO_256 = 3'd2,
    RATIO_384 = 3'd3,
    RATIO_512 = 3'd4
  } ratio_e;

  // Master cycles per bit clock for a ratio code and format flag.
  function automatic logic [DIV_W-1:0] bclk_div(input logic [2:0] code, input logic wide);
    logic [DIV_W-1:0] n;
    case (code)
      RATIO_128: n = wide ? DIV_W'(2) : DIV_W'(4);
      RATIO_192: n = DIV_W'(4);
      RATIO_384: n = DIV_W'(8);
      RATIO_512: n = wide ? DIV_W'(8) : DIV_W'(16);
      default:   n = wide ? DIV_W'(4) : DIV_W'(8);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bclk_edge_sense.sv
`timescale 1ns/1ps
module bclk_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  input  logic pin_i,
  output logic frame_edge,
  output logic frame_fall,
  output logic pin_rise
);
  logic frame_q;
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      frame_q <= frame_i;
      pin_q   <= pin_i;
    end
  end

  assign frame_edge = frame_i ^ frame_q;
  assign frame_fall = frame_q & ~frame_i;
  assign pin_rise   = pin_i & ~pin_q;
endmodule

// File: rtl/bclk_mode_detect.sv
`timescale 1ns/1ps
module bclk_mode_detect #(
  parameter int RISES_TO_ENTER = 16,
  parameter int IDLE_TO_EXIT   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_edge,
  input  logic frame_fall,
  input  logic pin_rise,
  output logic ext_q,
  output logic ext_d
);
  localparam int RW = $clog2(RISES_TO_ENTER + 1);
  localparam int IW = $clog2(IDLE_TO_EXIT + 1);

  logic [RW-1:0] rise_cnt, rise_base, rise_nxt;
  logic [IW-1:0] idle_cnt, idle_nxt;
  logic          seen_q;
  logic          enter, leave;

  // Rises within the current frame-clock half, saturating.
  always_comb begin
    rise_base = frame_edge ? '0 : rise_cnt;
    if (pin_rise && rise_base != RW'(RISES_TO_ENTER))
      rise_nxt = rise_base + 1'b1;
    else
      rise_nxt = rise_base;
  end

  // Idle frames: frames that ended without a rise, saturating.
  always_comb begin
    if (seen_q)
      idle_nxt = '0;
    else if (idle_cnt != IW'(IDLE_TO_EXIT))
      idle_nxt = idle_cnt + 1'b1;
    else
      idle_nxt = idle_cnt;
  end

  assign enter = !ext_q && (rise_nxt == RW'(RISES_TO_ENTER));
  assign leave = ext_q && frame_fall && (idle_nxt == IW'(IDLE_TO_EXIT));
  assign ext_d = enter ? 1'b1 : (leave ? 1'b0 : ext_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      idle_cnt <= '0;
      seen_q   <= 1'b0;
      ext_q    <= 1'b0;
    end else begin
      rise_cnt <= rise_nxt;
      ext_q    <= ext_d;
      if (enter) begin
        idle_cnt <= '0;
        seen_q   <= 1'b1;
      end else if (frame_fall) begin
        idle_cnt <= idle_nxt;
        seen_q   <= pin_rise;
      end else if (pin_rise) begin
        seen_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bclk_deemph_latch.sv
`timescale 1ns/1ps
module bclk_deemph_latch #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_fall,
  input  logic pin_i,
  input  logic ext_cur,
  input  logic ext_nxt,
  output logic deemph_q
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] low_run, high_run;
  logic [CW-1:0] low_nxt, high_nxt;

  always_comb begin
    low_nxt  = low_run;
    high_nxt = high_run;
    if (!pin_i) begin
      high_nxt = '0;
      if (low_run != CW'(RUN_LEN)) low_nxt = low_run + 1'b1;
    end else begin
      low_nxt = '0;
      if (high_run != CW'(RUN_LEN)) high_nxt = high_run + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
      deemph_q <= 1'b0;
    end else if (ext_cur || ext_nxt) begin
      low_run  <= '0;
      high_run <= '0;
      deemph_q <= 1'b0;
    end else if (frame_fall) begin
      low_run  <= low_nxt;
      high_run <= high_nxt;
      if (low_nxt == CW'(RUN_LEN))  deemph_q <= 1'b1;
      if (high_nxt == CW'(RUN_LEN)) deemph_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bclk_divider.sv
`timescale 1ns/1ps
module bclk_divider #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_edge,
  input  logic [DIV_W-1:0] div_n,
  output logic             bclk_q
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (frame_edge)
      cnt_d = '0;
    else if (cnt_q >= div_n - 1'b1)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= (cnt_d >= (div_n >> 1));
    end
  end
endmodule

// File: rtl/bclk_mode_sense.sv
`timescale 1ns/1ps
module bclk_mode_sense
  import bclk_mode_pkg::*;
#(
  parameter int RISES_TO_ENTER = 16,
  parameter int IDLE_TO_EXIT   = 2,
  parameter int RUN_LEN        = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_clk_i,
  input  logic       shared_pin_i,
  input  logic [2:0] ratio_sel_i,
  input  logic       wide_fmt_i,
  output logic       ext_mode_o,
  output logic       deemph_en_o,
  output logic       bit_clk_o
);
  logic             frame_edge, frame_fall, pin_rise;
  logic             ext_q, ext_d;
  logic             bclk_int;
  logic [DIV_W-1:0] div_n;

  assign div_n = bclk_div(ratio_sel_i, wide_fmt_i);

  bclk_edge_sense edge_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_i    (frame_clk_i),
    .pin_i      (shared_pin_i),
    .frame_edge (frame_edge),
    .frame_fall (frame_fall),
    .pin_rise   (pin_rise)
  );

  bclk_mode_detect #(
    .RISES_TO_ENTER (RISES_TO_ENTER),
    .IDLE_TO_EXIT   (IDLE_TO_EXIT)
  ) mode_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_edge (frame_edge),
    .frame_fall (frame_fall),
    .pin_rise   (pin_rise),
    .ext_q      (ext_q),
    .ext_d      (ext_d)
  );

  bclk_deemph_latch #(
    .RUN_LEN (RUN_LEN)
  ) dem_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_fall (frame_fall),
    .pin_i      (shared_pin_i),
    .ext_cur    (ext_q),
    .ext_nxt    (ext_d),
    .deemph_q   (deemph_en_o)
  );

  bclk_divider #(
    .DIV_W (DIV_W)
  ) div_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_edge (frame_edge),
    .div_n      (div_n),
    .bclk_q     (bclk_int)
  );

  assign ext_mode_o = ext_q;
  assign bit_clk_o  = ext_q ? shared_pin_i : bclk_int;
endmodule

// File: rtl/bclk_mode_sense_chk.sv
`timescale 1ns/1ps
module bclk_mode_sense_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_clk_i,
  input logic shared_pin_i,
  input logic ext_mode_o,
  input logic deemph_en_o,
  input logic bit_clk_o
);
  logic f_q, p_q;
  logic f_fall, f_edge, p_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= 1'b0;
      p_q <= 1'b0;
    end else begin
      f_q <= frame_clk_i;
      p_q <= shared_pin_i;
    end
  end

  assign f_fall = f_q & ~frame_clk_i;
  assign f_edge = f_q ^ frame_clk_i;
  assign p_rise = shared_pin_i & ~p_q;

  // R2
  ext_enter_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_mode_o) |-> $past(p_rise));

  // R3
  ext_leave_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_mode_o) |-> $past(f_fall));

  // R4
  deemph_on_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deemph_en_o) |-> $past(f_fall) && !ext_mode_o);

  // R6
  deemph_off_in_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode_o |-> !deemph_en_o);

  // R8
  bclk_low_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(f_edge) && !ext_mode_o |-> !bit_clk_o);
endmodule

bind bclk_mode_sense bclk_mode_sense_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_clk_i  (frame_clk_i),
  .shared_pin_i (shared_pin_i),
  .ext_mode_o   (ext_mode_o),
  .deemph_en_o  (deemph_en_o),
  .bit_clk_o    (bit_clk_o)
);

// File: tb/bclk_mode_sense_tb.sv
`timescale 1ns/1ps
module bclk_mode_sense_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clk_i = 1'b0;
  logic       shared_pin_i = 1'b0;
  logic [2:0] ratio_sel_i = 3'd2;
  logic       wide_fmt_i = 1'b0;
  logic       ext_mode_o, deemph_en_o, bit_clk_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bclk_mode_sense dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_clk_i  (frame_clk_i),
    .shared_pin_i (shared_pin_i),
    .ratio_sel_i  (ratio_sel_i),
    .wide_fmt_i   (wide_fmt_i),
    .ext_mode_o   (ext_mode_o),
    .deemph_en_o  (deemph_en_o),
    .bit_clk_o    (bit_clk_o)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pin_pulse();
    shared_pin_i = 1'b1; cyc();
    shared_pin_i = 1'b0; cyc();
  endtask

  task automatic frame_idle();
    frame_clk_i = 1'b1; cyc(); cyc();
    frame_clk_i = 1'b0; cyc(); cyc();
  endtask

  task automatic frame_with_rise();
    frame_clk_i = 1'b1; cyc(); cyc();
    pin_pulse();
    frame_clk_i = 1'b0; cyc(); cyc();
  endtask

  task automatic frame_level(input logic lvl);
    shared_pin_i = lvl;
    frame_idle();
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check(ext_mode_o == 1'b0, "R1 ext_mode", int'(ext_mode_o), 0);
    check(deemph_en_o == 1'b0, "R1 deemph", int'(deemph_en_o), 0);

    // R4: four low samples not enough, fifth enables
    repeat (4) frame_level(1'b0);
    check(deemph_en_o == 1'b0, "R4 four lows", int'(deemph_en_o), 0);
    frame_level(1'b0);
    check(deemph_en_o == 1'b1, "R4 five lows", int'(deemph_en_o), 1);
    // R5: four highs hold, fifth disables
    repeat (4) frame_level(1'b1);
    check(deemph_en_o == 1'b1, "R5 four highs", int'(deemph_en_o), 1);
    frame_level(1'b1);
    check(deemph_en_o == 1'b0, "R5 five highs", int'(deemph_en_o), 0);
    // R4: broken run restarts
    repeat (3) frame_level(1'b0);
    frame_level(1'b1);
    repeat (4) frame_level(1'b0);
    check(deemph_en_o == 1'b0, "R4 broken run", int'(deemph_en_o), 0);
    frame_level(1'b0);
    check(deemph_en_o == 1'b1, "R4 run after break", int'(deemph_en_o), 1);
    check(ext_mode_o == 1'b0, "R2 no entry from slow level", int'(ext_mode_o), 0);

    // R7 / R8: divider sweep
    shared_pin_i = 1'b0;
    for (int r = 0; r < 5; r++) begin
      for (int w = 0; w < 2; w++) begin
        int mclk, bpf, n, errs;
        mclk = (r == 0) ? 128 : (r == 1) ? 192 : (r == 2) ? 256 : (r == 3) ? 384 : 512;
        bpf  = (r == 1 || r == 3) ? 48 : (w != 0 ? 64 : 32);
        n    = mclk / bpf;
        errs = 0;
        ratio_sel_i = 3'(r);
        wide_fmt_i  = 1'(w);
        cyc(); cyc();
        frame_clk_i = ~frame_clk_i;
        for (int j = 0; j < 2 * n; j++) begin
          cyc();
          if (bit_clk_o != ((j % n) >= (n / 2))) errs++;
        end
        check(errs == 0, $sformatf("R7 R8 ratio=%0d wide=%0d", mclk, w), errs, 0);
      end
    end
    ratio_sel_i = 3'd2;
    wide_fmt_i  = 1'b0;

    // R2: 15 rises, frame edge, 15 rises -> no entry
    cyc();
    repeat (15) pin_pulse();
    check(ext_mode_o == 1'b0, "R2 fifteen rises", int'(ext_mode_o), 0);
    frame_clk_i = ~frame_clk_i;
    cyc();
    repeat (15) pin_pulse();
    check(ext_mode_o == 1'b0, "R2 count restarts at edge", int'(ext_mode_o), 0);
    shared_pin_i = 1'b1;
    cyc();
    check(ext_mode_o == 1'b1, "R2 sixteenth rise", int'(ext_mode_o), 1);
    check(deemph_en_o == 1'b0, "R6 cleared on entry", int'(deemph_en_o), 0);
    shared_pin_i = 1'b0;
    cyc();

    // R9: pass-through
    shared_pin_i = 1'b1; #1;
    check(bit_clk_o == 1'b1, "R9 follow high", int'(bit_clk_o), 1);
    shared_pin_i = 1'b0; #1;
    check(bit_clk_o == 1'b0, "R9 follow low", int'(bit_clk_o), 0);
    cyc();

    // R6: low level at frame falls ignored while external
    repeat (6) frame_with_rise();
    check(ext_mode_o == 1'b1, "R3 stays with rises", int'(ext_mode_o), 1);
    check(deemph_en_o == 1'b0, "R6 lows ignored", int'(deemph_en_o), 0);

    // R3: idle counting, reset by a rise, then exit
    frame_idle();
    check(ext_mode_o == 1'b1, "R3 one idle frame", int'(ext_mode_o), 1);
    frame_with_rise();
    frame_idle();
    check(ext_mode_o == 1'b1, "R3 rise restarts idle count", int'(ext_mode_o), 1);
    frame_idle();
    check(ext_mode_o == 1'b0, "R3 exit after two idle frames", int'(ext_mode_o), 0);

    // R6: exit sample discarded; five fresh lows needed
    repeat (4) frame_level(1'b0);
    check(deemph_en_o == 1'b0, "R6 four lows after exit", int'(deemph_en_o), 0);
    frame_level(1'b0);
    check(deemph_en_o == 1'b1, "R6 R4 fifth low after exit", int'(deemph_en_o), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule